// File: doc/BRIEF.md
# Memory Protection Region Programming Interface

This block holds the programmable state of an eight-region memory protection unit and presents it on a simple register bus. The bus is single-cycle. Software uses it to switch the unit on, to choose whether a background map applies, and to program each region. A region has a base address, an enable, a size code, eight subregion-disable bits, a permission code and six memory attribute bits. Every field except the memory attribute bits is driven out on flat per-region vectors to a separate access checker. The memory attribute bits are only stored and read back.

Four word addresses make up the map. The control register is at address 0. The region-select register is at address 1. The base register is at address 2, and the attribute register is at address 3. Both the base and the attribute registers act on the region held in the region-select register. A base write that carries its valid flag is the exception: it first reselects the region from its own low bits. With this, startup code can place every region using only base and attribute writes. Later code can pick one region and change a single field of it with a read-modify-write.

Top module: `mpuRegIf`

## Requirements
- R1: At address 0, bit 0 is the unit enable (`unitEnable`) and bit 2 is the background-map enable (`backgroundEnable`). Writing 1 sets only the unit enable. Writing 5 sets both. Both bits read back in the same positions.
- R2: At address 1, the region select keeps only the low 3 bits of the write data. Higher bits are dropped, so writing 13 selects region 5.
- R3: At address 2, a write with bit 4 (valid) set and bits 3:0 below 8 does two things: it loads the region select from bits 3:0, and it stores bits 31:5 as the base of that newly selected region.
- R4: At address 2, a write with bit 4 clear stores bits 31:5 into the currently selected region and leaves the selection unchanged.
- R5: At address 3, a write stores five fields into the selected region. Bit 0 is the enable, bits 5:1 the size, bits 15:8 the subregion disables, bits 21:16 the memory attributes and bits 26:24 the permission. Region i drives its fields on slice i of `regionEnable`, `regionBase` (27 bits each), `regionSize` (5), `regionSrd` (8) and `regionPerm` (3).
- R6: Attribute reads and writes reach only the selected region, and every other region keeps its fields.
- R7: A read of address 2 returns the selected region's base in bits 31:5, 0 in bit 4 and the region select in bits 3:0.
- R8: A valid base write whose bits 3:0 hold 8 or more leaves the selection unchanged. Its base goes into the currently selected region.
- R9: Reset clears the control bits, the region select and every region's fields, so the unit comes up disabled with all regions off.
- R10: Reserved bits read as 0 and ignore writes. This covers control bits other than 0 and 2, and attribute bits 7:6, 23:22 and 31:27.
- R11: A write takes effect at the clock edge that samples it. Read data reflects the stored state without delay, so it still shows the old value during the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Word address: 0 control, 1 region select, 2 base, 3 attribute |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data of the addressed register |
| unitEnable | output | 1 | Global protection enable |
| backgroundEnable | output | 1 | Background map enable |
| regionEnable | output | 8 | Per-region enable |
| regionBase | output | 216 | Per-region base address bits 31:5, 27 bits per region |
| regionSize | output | 40 | Per-region size code, 5 bits per region |
| regionSrd | output | 64 | Per-region subregion disables, 8 bits per region |
| regionPerm | output | 24 | Per-region permission code, 3 bits per region |

## Verification
The hardest case to reach is a valid base write whose region field is out of range. It must leave the selection alone and still deliver its base. To make the result visible, the stimulus first selects region 3 through a valid base write and fills that region's attributes with all ones. It then issues the out-of-range write and reads back both the selection and the base. Region 5 is then programmed through the region-select path. Going back to region 3 confirms that its attributes and its base survived the writes to region 5.

// File: rtl/mpuRegPkg.sv
package mpuRegPkg;
  localparam int DATA_W  = 32;
  localparam int BASE_LSB = 5;
  localparam int BASE_W  = DATA_W - BASE_LSB;
  localparam int SIZE_W  = 5;
  localparam int SRD_W   = 8;
  localparam int MATTR_W = 6;
  localparam int PERM_W  = 3;
  localparam int VALID_BIT = 4;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_RSEL = 2'd1,
    ADDR_BASE = 2'd2,
    ADDR_ATTR = 2'd3
  } regAddrE;

  // strobes from control to datapath
  typedef struct packed {
    logic baseWr;
    logic attrWr;
  } dpStrobeT;

  typedef struct packed {
    logic               en;
    logic [SIZE_W-1:0]  size;
    logic [SRD_W-1:0]   srd;
    logic [MATTR_W-1:0] mattr;
    logic [PERM_W-1:0]  perm;
  } attrT;

  function automatic attrT unpackAttr(input logic [DATA_W-1:0] d);
    attrT a;
    a.en    = d[0];
    a.size  = d[5:1];
    a.srd   = d[15:8];
    a.mattr = d[21:16];
    a.perm  = d[26:24];
    return a;
  endfunction

  function automatic logic [DATA_W-1:0] packAttr(input attrT a);
    return {5'd0, a.perm, 2'd0, a.mattr, a.srd, 2'd0, a.size, a.en};
  endfunction
endpackage

// File: rtl/mpuRegCtrl.sv
module mpuRegCtrl
  import mpuRegPkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int RW = $clog2(NUM_REGIONS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [BASE_W-1:0] selBase,
  input  attrT              selAttr,
  output dpStrobeT          strobe,
  output logic [RW-1:0]     tgtRegion,
  output logic [RW-1:0]     regionSel,
  output logic              unitEnable,
  output logic              backgroundEnable,
  output logic [DATA_W-1:0] busRdData
);
  logic          ctrlWr, selWr, baseWr, attrWr;
  logic          validSel;
  logic [RW-1:0] selNext;

  assign ctrlWr = busWrEn && (regAddrE'(busAddr) == ADDR_CTRL);
  assign selWr  = busWrEn && (regAddrE'(busAddr) == ADDR_RSEL);
  assign baseWr = busWrEn && (regAddrE'(busAddr) == ADDR_BASE);
  assign attrWr = busWrEn && (regAddrE'(busAddr) == ADDR_ATTR);

  // valid flag with an in-range region field reselects
  assign validSel = baseWr && busWrData[VALID_BIT]
                    && ({28'd0, busWrData[3:0]} < NUM_REGIONS);

  always_comb begin
    selNext = regionSel;
    if (selWr)         selNext = busWrData[RW-1:0];
    else if (validSel) selNext = busWrData[RW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regionSel        <= '0;
      unitEnable       <= 1'b0;
      backgroundEnable <= 1'b0;
    end else begin
      regionSel <= selNext;
      if (ctrlWr) begin
        unitEnable       <= busWrData[0];
        backgroundEnable <= busWrData[2];
      end
    end
  end

  assign strobe.baseWr = baseWr;
  assign strobe.attrWr = attrWr;
  assign tgtRegion     = selNext;

  always_comb begin
    unique case (regAddrE'(busAddr))
      ADDR_CTRL: busRdData = {29'd0, backgroundEnable, 1'b0, unitEnable};
      ADDR_RSEL: busRdData = DATA_W'(regionSel);
      ADDR_BASE: busRdData = {selBase, 1'b0, 4'(regionSel)};
      default:   busRdData = packAttr(selAttr);
    endcase
  end
endmodule

// File: rtl/mpuRegData.sv
module mpuRegData
  import mpuRegPkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int RW = $clog2(NUM_REGIONS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobeT                      strobe,
  input  logic [RW-1:0]                 tgtRegion,
  input  logic [RW-1:0]                 rdRegion,
  input  logic [DATA_W-1:0]             wrData,
  output logic [BASE_W-1:0]             selBase,
  output attrT                          selAttr,
  output logic [NUM_REGIONS-1:0]        regionEnable,
  output logic [NUM_REGIONS*BASE_W-1:0] regionBase,
  output logic [NUM_REGIONS*SIZE_W-1:0] regionSize,
  output logic [NUM_REGIONS*SRD_W-1:0]  regionSrd,
  output logic [NUM_REGIONS*PERM_W-1:0] regionPerm
);
  logic [BASE_W-1:0] baseQ [NUM_REGIONS];
  attrT              attrQ [NUM_REGIONS];
  attrT              attrIn;

  assign attrIn = unpackAttr(wrData);

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : gRegion
    logic hit;
    assign hit = (tgtRegion == RW'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ[i] <= '0;
        attrQ[i] <= '0;
      end else begin
        if (strobe.baseWr && hit) baseQ[i] <= wrData[DATA_W-1:BASE_LSB];
        if (strobe.attrWr && hit) attrQ[i] <= attrIn;
      end
    end

    assign regionEnable[i]                 = attrQ[i].en;
    assign regionBase[i*BASE_W +: BASE_W]  = baseQ[i];
    assign regionSize[i*SIZE_W +: SIZE_W]  = attrQ[i].size;
    assign regionSrd[i*SRD_W +: SRD_W]     = attrQ[i].srd;
    assign regionPerm[i*PERM_W +: PERM_W]  = attrQ[i].perm;
  end

  assign selBase = baseQ[rdRegion];
  assign selAttr = attrQ[rdRegion];
endmodule

// File: rtl/mpuRegIf.sv
module mpuRegIf
  import mpuRegPkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [1:0]                    busAddr,
  input  logic                          busWrEn,
  input  logic [31:0]                   busWrData,
  output logic [31:0]                   busRdData,
  output logic                          unitEnable,
  output logic                          backgroundEnable,
  output logic [NUM_REGIONS-1:0]        regionEnable,
  output logic [NUM_REGIONS*27-1:0]     regionBase,
  output logic [NUM_REGIONS*5-1:0]      regionSize,
  output logic [NUM_REGIONS*8-1:0]      regionSrd,
  output logic [NUM_REGIONS*3-1:0]      regionPerm
);
  localparam int RW = $clog2(NUM_REGIONS);

  dpStrobeT          strobe;
  logic [RW-1:0]     tgtRegion;
  logic [RW-1:0]     regionSel;
  logic [BASE_W-1:0] selBase;
  attrT              selAttr;

  mpuRegCtrl #(.NUM_REGIONS(NUM_REGIONS)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .selBase(selBase), .selAttr(selAttr),
    .strobe(strobe), .tgtRegion(tgtRegion), .regionSel(regionSel),
    .unitEnable(unitEnable), .backgroundEnable(backgroundEnable),
    .busRdData(busRdData)
  );

  mpuRegData #(.NUM_REGIONS(NUM_REGIONS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tgtRegion(tgtRegion),
    .rdRegion(regionSel), .wrData(busWrData), .selBase(selBase),
    .selAttr(selAttr), .regionEnable(regionEnable), .regionBase(regionBase),
    .regionSize(regionSize), .regionSrd(regionSrd), .regionPerm(regionPerm)
  );
endmodule

// File: rtl/mpuRegChk.sv
module mpuRegChk #(
  parameter int NUM_REGIONS = 8,
  localparam int RW = $clog2(NUM_REGIONS)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [1:0]             busAddr,
  input logic                   busWrEn,
  input logic [31:0]            busWrData,
  input logic [31:0]            busRdData,
  input logic                   unitEnable,
  input logic [NUM_REGIONS-1:0] regionEnable,
  input logic [RW-1:0]          regionSel
);
  // R1
  ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd0) |=> (unitEnable == $past(busWrData[0])));

  // R3
  valid_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd2 && busWrData[4] && ({28'd0, busWrData[3:0]} < NUM_REGIONS))
    |=> (regionSel == $past(busWrData[RW-1:0])));

  // R8
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd2 && busWrData[4] && ({28'd0, busWrData[3:0]} >= NUM_REGIONS))
    |=> $stable(regionSel));

  // R6
  en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == 2'd3) |=> $stable(regionEnable));

  // R6
  one_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($countones(regionEnable ^ $past(regionEnable)) <= 1));

  // R10
  ctrl_rsv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd0) |-> ((busRdData & ~32'h5) == 32'd0));

  // R7
  base_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd2) |-> (!busRdData[4] && busRdData[3:0] == 4'(regionSel)));
endmodule

bind mpuRegIf mpuRegChk #(.NUM_REGIONS(NUM_REGIONS)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .unitEnable(unitEnable),
  .regionEnable(regionEnable), .regionSel(regionSel)
);

// File: tb/sim_mpuRegIf.sv
`timescale 1ns/1ps
module sim_mpuRegIf;
  localparam int NR = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    busAddr = 2'd0;
  logic          busWrEn = 1'b0;
  logic [31:0]   busWrData = 32'd0;
  logic [31:0]   busRdData;
  logic          unitEnable, backgroundEnable;
  logic [NR-1:0] regionEnable;
  logic [NR*27-1:0] regionBase;
  logic [NR*5-1:0]  regionSize;
  logic [NR*8-1:0]  regionSrd;
  logic [NR*3-1:0]  regionPerm;

  int checkCnt = 0;
  int failCnt = 0;
  int cycleCnt = 0;

  always #10 clk = ~clk;

  mpuRegIf #(.NUM_REGIONS(NR)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .unitEnable(unitEnable),
    .backgroundEnable(backgroundEnable), .regionEnable(regionEnable),
    .regionBase(regionBase), .regionSize(regionSize), .regionSrd(regionSrd),
    .regionPerm(regionPerm)
  );

  typedef struct packed {
    logic        isRead;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vecT;

  localparam int NV = 22;
  localparam vecT VEC [NV] = '{
    '{1'b0, 2'd0, 32'hFFFF_FFFF, 4'd1},
    '{1'b1, 2'd0, 32'h0000_0005, 4'd10}, // R10 control reserved bits
    '{1'b0, 2'd0, 32'h0000_0001, 4'd1},
    '{1'b1, 2'd0, 32'h0000_0001, 4'd1},  // R1 enable only
    '{1'b0, 2'd2, 32'h1000_0013, 4'd3},
    '{1'b1, 2'd1, 32'h0000_0003, 4'd3},  // R3 reselect
    '{1'b1, 2'd2, 32'h1000_0003, 4'd7},  // R7 base readback
    '{1'b0, 2'd3, 32'hFFFF_FFFF, 4'd5},
    '{1'b1, 2'd3, 32'h073F_FF3F, 4'd10}, // R10 attribute reserved bits
    '{1'b0, 2'd2, 32'h2000_001C, 4'd8},
    '{1'b1, 2'd1, 32'h0000_0003, 4'd8},  // R8 selection kept
    '{1'b1, 2'd2, 32'h2000_0003, 4'd8},  // R8 base to current region
    '{1'b0, 2'd1, 32'h0000_000D, 4'd2},
    '{1'b1, 2'd1, 32'h0000_0005, 4'd2},  // R2 3-bit select
    '{1'b0, 2'd2, 32'h4000_0FE7, 4'd4},
    '{1'b1, 2'd2, 32'h4000_0FE5, 4'd4},  // R4 plain base write
    '{1'b1, 2'd3, 32'h0000_0000, 4'd6},  // R6 region 5 untouched so far
    '{1'b0, 2'd3, 32'h0300_0001, 4'd5},
    '{1'b1, 2'd3, 32'h0300_0001, 4'd5},  // R5 attribute write
    '{1'b0, 2'd1, 32'h0000_0003, 4'd6},
    '{1'b1, 2'd3, 32'h073F_FF3F, 4'd6},  // R6 region 3 kept
    '{1'b1, 2'd2, 32'h2000_0003, 4'd6}   // R6 region 3 base kept
  };

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt == 20000) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog actual=%0d expected=done", cycleCnt);
      summary();
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9 reset state
    busRead(2'd0, rd); check("R9 ctrl", rd, 0);
    busRead(2'd1, rd); check("R9 select", rd, 0);
    check("R9 enables", {unitEnable, backgroundEnable, regionEnable}, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].isRead) begin
        busRead(VEC[i].addr, rd);
        check($sformatf("R%0d vec%0d", VEC[i].req, i), rd, VEC[i].data);
      end else begin
        busWrite(VEC[i].addr, VEC[i].data);
      end
    end

    // R5 flat outputs
    check("R5 enables", regionEnable, 8'h28);
    check("R5 size3", regionSize[3*5 +: 5], 5'h1F);
    check("R5 srd3", regionSrd[3*8 +: 8], 8'hFF);
    check("R5 perm3", regionPerm[3*3 +: 3], 3'h7);
    check("R5 perm5", regionPerm[5*3 +: 3], 3'h3);
    check("R5 base3", regionBase[3*27 +: 27], 27'h100_0000);
    check("R5 base5", regionBase[5*27 +: 27], 27'h200_007F);
    check("R1 outputs", {unitEnable, backgroundEnable}, 2'b10);

    // R1 both enables
    busWrite(2'd0, 32'h5);
    check("R1 both", {unitEnable, backgroundEnable}, 2'b11);

    // R11 old value during write, new after edge
    @(negedge clk);
    busAddr = 2'd0; busWrData = 32'h0; busWrEn = 1'b1;
    #1 check("R11 during write", busRdData, 32'h5);
    @(negedge clk);
    busWrEn = 1'b0;
    #1 check("R11 after edge", busRdData, 32'h0);

    // R6 disable region 3 only
    busWrite(2'd3, 32'h0);
    check("R6 only region 3 off", regionEnable, 8'h20);

    // R9 reset mid-run
    busWrite(2'd0, 32'h5);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R9 enables after reset", {unitEnable, backgroundEnable, regionEnable}, 0);
    busRead(2'd1, rd); check("R9 select after reset", rd, 0);

    summary();
  end
endmodule